// File: doc/BRIEF.md
# Shared Bus Arbiter with Parking and Slave Watchdog

This block decides which of up to 16 bus masters owns a shared on-chip bus. Each master raises a request line; the arbiter registers a one-hot grant and a master index. Once a master is granted, a transfer is in progress. The grant stays fixed until the slave acknowledges or a watchdog ends the transfer. When the transfer ends, the next owner is chosen in that same cycle, so the bus never sits idle between back-to-back transfers.

Priority comes from an ordered list of master numbers, with slot 0 highest. A parameter picks how that list behaves. In fixed mode, software writes the list through a small register port. In dynamic mode, hardware keeps the list in least-recently-used order. When nobody requests, a control register chooses one of three parking policies: no grant, a chosen master, or the master granted last. A parked master that raises its request takes the bus at once, ahead of any other requester. If no acknowledge arrives within 16 cycles of a grant, the watchdog ends the transfer and pulses a timeout. A sticky copy of that timeout is kept in a status register.

Top module: `bus_arbiter_park`

## Requirements
- R1: After reset, no grant is given, `gnt_id` is 0 and `bus_timeout` is low. Priority slot k (address 2+k) reads k, and the control (address 0) and status (address 1) registers read 0.
- R2: In fixed mode, a new grant goes to the requesting master that sits in the lowest-numbered priority slot. The grant appears on the clock edge after the request is seen by a free bus.
- R3: In fixed mode, writing value v (bits 3:0) to slot k swaps v into slot k, and the slot that held v takes the old content of k, so the list stays a permutation. A write with v not below the master count is ignored. In dynamic mode, all slot writes are ignored.
- R4: In dynamic mode, each new grant moves the granted master to the last slot. The masters behind it each move up one slot.
- R5: During a transfer the grant does not change until `xfer_ack` or a watchdog expiry. A transfer that ends with requests pending re-grants on that same edge, with no idle cycle.
- R6: If no `xfer_ack` arrives in the 16 cycles after a grant, the transfer ends and `bus_timeout` is high for exactly one cycle. An acknowledge in the 16th cycle ends the transfer normally, with no timeout.
- R7: Park mode 1 (control bits 1:0 = 1) grants the idle bus to the master in control bits 7:4. If that number is not below the master count, no grant is given.
- R8: Park mode 2 grants the idle bus to the master granted most recently.
- R9: Park modes 0 and 3 leave the idle bus with no grant.
- R10: A parked master that raises its request becomes the owner at the next edge, ahead of higher-priority requesters. Its grant stays high throughout.
- R11: Status bit 0 shows a transfer in progress and bits 7:4 show the grant holder. Bit 8 is set by a watchdog expiry and cleared by writing 1 to it.
- R12: `xfer_ack` while no transfer is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_M | Request per master |
| xfer_ack | input | 1 | Slave acknowledge that ends the current transfer |
| gnt | output | NUM_M | One-hot grant, registered |
| gnt_id | output | 4 | Index of the grant holder (0 when none) |
| bus_timeout | output | 1 | One-cycle pulse after a watchdog expiry |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address: 0 control, 1 status, 2+k priority slot k |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr`, combinational |

## Verification
The assertions assume that requests and the acknowledge are synchronous and are stable around the rising edge. They also assume the acknowledge refers only to the transfer of the current holder, so an acknowledge is only counted while a transfer is in progress. The bench changes every input just after the falling edge and drives the acknowledge for at most one cycle per transfer. It holds requests for as long as the scenario needs. Two copies of the arbiter, one per priority mode, receive the same stimulus. Because transfer timing does not depend on which master wins, each copy can be compared against its own reference ordering. The bench writes out-of-range slot values and an out-of-range park index on purpose. This lets it observe that they are ignored.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int MAX_M  = 16;
  localparam int ID_W   = 4;
  localparam int CFG_AW = 5;
  localparam int CFG_DW = 16;

  typedef logic [ID_W-1:0] mid_t;
  typedef mid_t [MAX_M-1:0] order_t;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_SEL   = 2'd1,
    PARK_LAST  = 2'd2,
    PARK_NONE2 = 2'd3
  } park_e;

  localparam logic [CFG_AW-1:0] A_CTRL  = 5'd0;
  localparam logic [CFG_AW-1:0] A_STAT  = 5'd1;
  localparam logic [CFG_AW-1:0] A_PRIO0 = 5'd2;

  // identity order: master i in slot i
  function automatic order_t order_reset();
    order_t o;
    for (int i = 0; i < MAX_M; i++) o[i] = mid_t'(i);
    return o;
  endfunction

  // {found, id}: first slot (lowest index) whose master requests
  function automatic logic [ID_W:0] pick_first(order_t o, logic [MAX_M-1:0] rq, int n);
    logic [ID_W:0] r;
    r = '0;
    for (int s = MAX_M - 1; s >= 0; s--)
      if (s < n && rq[o[s]]) r = {1'b1, o[s]};
    return r;
  endfunction

  // move id to the last used slot, close the gap behind it
  function automatic order_t lru_demote(order_t o, mid_t id, int n);
    order_t r;
    logic   seen;
    r    = o;
    seen = 1'b0;
    for (int s = 0; s < MAX_M; s++) begin
      if (s < n) begin
        if (o[s] == id) seen = 1'b1;
        if (seen && (s + 1 < n)) r[s] = o[s+1];
      end
    end
    r[n-1] = id;
    return r;
  endfunction

  // place id into slot, old slot content goes where id was
  function automatic order_t swap_in(order_t o, int slot, mid_t id, int n);
    order_t r;
    r = o;
    for (int s = 0; s < MAX_M; s++) begin
      if (s < n) begin
        if (s == slot)      r[s] = id;
        else if (o[s] == id) r[s] = o[slot];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/arb_order.sv
module arb_order
  import arb_pkg::*;
#(
  parameter int NUM_M = 4,
  parameter bit DYN   = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  mid_t            upd_id,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_slot,
  input  mid_t            wr_id,
  output order_t          ord
);
  order_t ord_q;

  generate
    if (DYN) begin : g_lru
      logic unused_wr;
      assign unused_wr = wr_en ^ (^wr_slot) ^ (^wr_id);
      always_ff @(posedge clk) begin
        if (!rst_n)   ord_q <= order_reset();
        else if (upd) ord_q <= lru_demote(ord_q, upd_id, NUM_M);
      end
    end else begin : g_fixed
      logic unused_upd;
      logic wr_ok;
      assign unused_upd = upd ^ (^upd_id);
      assign wr_ok = wr_en && (int'(wr_slot) < NUM_M) && (int'(wr_id) < NUM_M);
      always_ff @(posedge clk) begin
        if (!rst_n)     ord_q <= order_reset();
        else if (wr_ok) ord_q <= swap_in(ord_q, int'(wr_slot), wr_id, NUM_M);
      end
    end
  endgenerate

  assign ord = ord_q;
endmodule

// File: rtl/arb_watchdog.sv
module arb_watchdog #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic ack,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                              cnt <= '0;
    else if (start)                          cnt <= '0;
    else if (run && cnt != CW'(LIMIT - 1))   cnt <= cnt + 1'b1;
  end

  assign expire = run && !ack && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/arb_regs.sv
module arb_regs
  import arb_pkg::*;
#(
  parameter int NUM_M = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              busy,
  input  mid_t              owner,
  input  logic              timeout_ev,
  input  order_t            ord,
  output park_e             park_mode,
  output mid_t              park_id,
  output logic              prio_we,
  output logic [ID_W-1:0]   prio_slot,
  output mid_t              prio_val,
  output logic [CFG_DW-1:0] cfg_rdata
);
  park_e mode_q;
  mid_t  pid_q;
  logic  sticky_q;
  logic  hit_prio;
  logic  unused_bits;

  assign unused_bits = ^{cfg_wdata[15:9], cfg_wdata[3:2]};

  assign hit_prio  = (cfg_addr >= A_PRIO0) && (int'(cfg_addr) < int'(A_PRIO0) + NUM_M);
  assign prio_we   = cfg_we && hit_prio;
  assign prio_slot = ID_W'(cfg_addr - A_PRIO0);
  assign prio_val  = cfg_wdata[ID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= PARK_NONE;
      pid_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == A_CTRL) begin
        mode_q <= park_e'(cfg_wdata[1:0]);
        pid_q  <= cfg_wdata[7:4];
      end
      if (timeout_ev)                                         sticky_q <= 1'b1;
      else if (cfg_we && cfg_addr == A_STAT && cfg_wdata[8])  sticky_q <= 1'b0;
    end
  end

  assign park_mode = mode_q;
  assign park_id   = pid_q;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_CTRL) begin
      cfg_rdata[1:0] = mode_q;
      cfg_rdata[7:4] = pid_q;
    end else if (cfg_addr == A_STAT) begin
      cfg_rdata[0]   = busy;
      cfg_rdata[7:4] = owner;
      cfg_rdata[8]   = sticky_q;
    end else if (hit_prio) begin
      cfg_rdata[ID_W-1:0] = ord[prio_slot];
    end
  end
endmodule

// File: rtl/bus_arbiter_park.sv
module bus_arbiter_park
  import arb_pkg::*;
#(
  parameter int NUM_M    = 4,
  parameter bit DYN_LRU  = 1'b0,
  parameter int WD_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_M-1:0]  req,
  input  logic              xfer_ack,
  output logic [NUM_M-1:0]  gnt,
  output logic [ID_W-1:0]   gnt_id,
  output logic              bus_timeout,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata
);
  logic            busy_q;
  logic            own_vld_q;
  mid_t            own_q;
  mid_t            last_q;
  logic            tmo_q;

  order_t          ord;
  park_e           park_mode;
  mid_t            park_id;
  logic            prio_we;
  logic [ID_W-1:0] prio_slot;
  mid_t            prio_val;

  logic            wd_expire;
  logic            xfer_end;
  logic            bus_free;
  logic [MAX_M-1:0] req_ext;
  logic [ID_W:0]   pick;
  logic            parked_hit;
  logic            new_grant;
  mid_t            win_id;
  logic            park_vld;
  mid_t            park_tgt;

  assign req_ext    = MAX_M'(req);
  assign xfer_end   = busy_q && (xfer_ack || wd_expire);
  assign bus_free   = !busy_q || xfer_end;
  assign pick       = pick_first(ord, req_ext, NUM_M);
  assign parked_hit = !busy_q && own_vld_q && req_ext[own_q];
  assign new_grant  = bus_free && (parked_hit || pick[ID_W]);
  assign win_id     = parked_hit ? own_q : pick[ID_W-1:0];

  always_comb begin
    park_vld = 1'b0;
    park_tgt = '0;
    case (park_mode)
      PARK_SEL: begin
        park_vld = int'(park_id) < NUM_M;
        park_tgt = park_vld ? park_id : '0;
      end
      PARK_LAST: begin
        park_vld = 1'b1;
        park_tgt = last_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      own_vld_q <= 1'b0;
      own_q     <= '0;
      last_q    <= '0;
      tmo_q     <= 1'b0;
    end else begin
      tmo_q <= wd_expire;
      if (new_grant) begin
        busy_q    <= 1'b1;
        own_vld_q <= 1'b1;
        own_q     <= win_id;
        last_q    <= win_id;
      end else if (bus_free) begin
        busy_q    <= 1'b0;
        own_vld_q <= park_vld;
        own_q     <= park_tgt;
      end
    end
  end

  arb_order #(.NUM_M(NUM_M), .DYN(DYN_LRU)) u_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (new_grant),
    .upd_id  (win_id),
    .wr_en   (prio_we),
    .wr_slot (prio_slot),
    .wr_id   (prio_val),
    .ord     (ord)
  );

  arb_watchdog #(.LIMIT(WD_LIMIT)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (new_grant),
    .run    (busy_q),
    .ack    (xfer_ack),
    .expire (wd_expire)
  );

  arb_regs #(.NUM_M(NUM_M)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .busy       (busy_q),
    .owner      (own_q),
    .timeout_ev (wd_expire),
    .ord        (ord),
    .park_mode  (park_mode),
    .park_id    (park_id),
    .prio_we    (prio_we),
    .prio_slot  (prio_slot),
    .prio_val   (prio_val),
    .cfg_rdata  (cfg_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_M; i++) begin : g_dec
      assign gnt[i] = own_vld_q && (own_q == ID_W'(i));
    end
  endgenerate

  assign gnt_id      = own_q;
  assign bus_timeout = tmo_q;
endmodule

// File: rtl/arb_chk.sv
module arb_chk
  import arb_pkg::*;
#(
  parameter int NUM_M = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_M-1:0] req,
  input logic             xfer_ack,
  input logic [NUM_M-1:0] gnt,
  input logic             bus_timeout,
  input logic             busy,
  input logic             xfer_end,
  input logic             new_grant,
  input park_e            park_mode,
  input order_t           ord
);
  localparam logic [MAX_M-1:0] FULL = MAX_M'((17'(1) << NUM_M) - 17'(1));
  logic [MAX_M-1:0] seen;

  always_comb begin
    seen = '0;
    for (int i = 0; i < NUM_M; i++) seen = seen | (MAX_M'(1) << ord[i]);
  end

  // R5: grant and ownership frozen while the transfer runs
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_end |=> $stable(gnt) && busy);

  // R2: a new grant always lands on a master that was requesting
  p_grant_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    new_grant |=> (gnt & $past(req)) != '0);

  // R6: timeout only follows a running transfer that saw no acknowledge
  p_timeout_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_timeout |-> $past(busy) && !$past(xfer_ack));

  // R6: the timeout is a single-cycle pulse
  p_timeout_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_timeout |=> !bus_timeout);

  // R9: idle bus with parking off carries no grant
  p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req == '0 && (park_mode == PARK_NONE || park_mode == PARK_NONE2) |=> gnt == '0);

  // R3: the priority list stays a permutation of master numbers
  p_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen == FULL);
endmodule

bind bus_arbiter_park arb_chk #(.NUM_M(NUM_M)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .xfer_ack    (xfer_ack),
  .gnt         (gnt),
  .bus_timeout (bus_timeout),
  .busy        (busy_q),
  .xfer_end    (xfer_end),
  .new_grant   (new_grant),
  .park_mode   (park_mode),
  .ord         (ord)
);

// File: tb/bus_arbiter_park_tb.sv
module bus_arbiter_park_tb;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic        ack = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [N-1:0] gnt_d, gnt_f;
  logic [3:0]  id_d, id_f;
  logic        to_d, to_f;
  logic [15:0] rd_d, rd_f;

  int total = 0;
  int bad = 0;
  logic [3:0] eo_d [N];
  logic [3:0] eo_f [N];

  always #10 clk = ~clk;

  bus_arbiter_park #(.NUM_M(N), .DYN_LRU(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_ack(ack), .gnt(gnt_d), .gnt_id(id_d),
    .bus_timeout(to_d), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_d));

  bus_arbiter_park #(.NUM_M(N), .DYN_LRU(1'b0)) u_fix (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_ack(ack), .gnt(gnt_f), .gnt_id(id_f),
    .bus_timeout(to_f), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_f));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // reference: scan slots from the top, first requester wins
  function automatic int mpick(input logic [3:0] o [N], input logic [N-1:0] p);
    for (int s = 0; s < N; s++)
      if (p[o[s]]) return int'(o[s]);
    return -1;
  endfunction

  // reference LRU: rebuild the list without w, then append w
  task automatic demote(input int w);
    logic [3:0] t [N];
    int k;
    k = 0;
    for (int s = 0; s < N; s++)
      if (int'(eo_d[s]) != w) begin
        t[k] = eo_d[s];
        k = k + 1;
      end
    t[N-1] = 4'(w);
    eo_d = t;
  endtask

  task automatic grant_chk(input string tag, input logic [N-1:0] p);
    int wd, wf;
    wd = mpick(eo_d, p);
    wf = mpick(eo_f, p);
    req = p;
    step();
    chk({tag, " dyn"}, 32'(gnt_d), 32'(N'(1) << wd));
    chk({tag, " fix"}, 32'(gnt_f), 32'(N'(1) << wf));
    demote(wd);
  endtask

  task automatic release_bus();
    ack = 1'b1;
    req = '0;
    step();
    ack = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] vd, output logic [15:0] vf);
    cfg_addr = a;
    #1;
    vd = rd_d;
    vf = rd_f;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_we    = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic swap_model(input int slot, input int v);
    for (int j = 0; j < N; j++)
      if (int'(eo_f[j]) == v) eo_f[j] = eo_f[slot];
    eo_f[slot] = 4'(v);
  endtask

  task automatic sweep(input string tag);
    for (int p = 1; p < (1 << N); p++) begin
      grant_chk(tag, N'(p));
      release_bus();
      chk("R9 idle after release", 32'({gnt_d, gnt_f}), 32'h0);
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired, run hung");
    summary();
    $finish;
  end

  initial begin : main
    logic [15:0] vd, vf;
    for (int i = 0; i < N; i++) begin
      eo_d[i] = 4'(i);
      eo_f[i] = 4'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 gnt", 32'({gnt_d, gnt_f}), 32'h0);
    chk("R1 gnt_id", 32'({id_d, id_f}), 32'h0);
    chk("R1 timeout", 32'({to_d, to_f}), 32'h0);
    for (int k = 0; k < N; k++) begin
      rd(5'(2 + k), vd, vf);
      chk("R1 slot dyn", 32'(vd), 32'(k));
      chk("R1 slot fix", 32'(vf), 32'(k));
    end
    rd(5'd0, vd, vf);
    chk("R1 ctrl", 32'({vd, vf}), 32'h0);
    rd(5'd1, vd, vf);
    chk("R1 status", 32'({vd, vf}), 32'h0);

    // R2 fixed order, R4 LRU order, all request patterns twice
    sweep("R2 R4 sweep a");
    sweep("R2 R4 sweep b");

    // R12 acknowledge on idle bus
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R12 gnt", 32'({gnt_d, gnt_f}), 32'h0);
    chk("R12 timeout", 32'({to_d, to_f}), 32'h0);
    rd(5'd1, vd, vf);
    chk("R12 status", 32'({vd[0], vf[0]}), 32'h0);
    grant_chk("R12 next grant", 4'b0110);
    release_bus();

    // R3 priority writes
    wr(5'd2, 16'd3);
    swap_model(0, 3);
    wr(5'd4, 16'd0);
    swap_model(2, 0);
    wr(5'd3, 16'd7);
    for (int k = 0; k < N; k++) begin
      rd(5'(2 + k), vd, vf);
      chk("R3 slot dyn", 32'(vd), 32'(eo_d[k]));
      chk("R3 slot fix", 32'(vf), 32'(eo_f[k]));
    end
    sweep("R3 R2 sweep c");

    // R5 hold and back-to-back regrant
    grant_chk("R5 first", 4'b0011);
    vd = 16'(gnt_d);
    vf = 16'(gnt_f);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5 hold dyn", 32'(gnt_d), 32'(vd));
      chk("R5 hold fix", 32'(gnt_f), 32'(vf));
    end
    ack = 1'b1;
    grant_chk("R5 regrant", 4'b0011);
    ack = 1'b0;
    rd(5'd1, vd, vf);
    chk("R5 busy", 32'({vd[0], vf[0]}), 32'h3);
    release_bus();

    // R6 watchdog expiry
    grant_chk("R6 grant", 4'b0001);
    req = '0;
    for (int k = 1; k < 16; k++) begin
      step();
      chk("R6 no early timeout", 32'({to_d, to_f}), 32'h0);
      chk("R6 grant held", 32'({gnt_d, gnt_f}), 32'h11);
    end
    step();
    chk("R6 timeout pulse", 32'({to_d, to_f}), 32'h3);
    chk("R6 bus freed", 32'({gnt_d, gnt_f}), 32'h0);
    step();
    chk("R6 pulse ends", 32'({to_d, to_f}), 32'h0);

    // R11 status
    rd(5'd1, vd, vf);
    chk("R11 sticky set", 32'({vd[8], vf[8]}), 32'h3);
    wr(5'd1, 16'h0100);
    rd(5'd1, vd, vf);
    chk("R11 sticky cleared", 32'({vd[8], vf[8]}), 32'h0);
    grant_chk("R11 grant", 4'b1000);
    rd(5'd1, vd, vf);
    chk("R11 status dyn", 32'(vd), 32'h31);
    chk("R11 status fix", 32'(vf), 32'h31);

    // R6 acknowledge in the last allowed cycle
    req = '0;
    for (int k = 1; k < 16; k++) step();
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R6 late ack no timeout", 32'({to_d, to_f}), 32'h0);
    chk("R6 late ack frees bus", 32'({gnt_d, gnt_f}), 32'h0);
    step();
    chk("R6 late ack no pulse", 32'({to_d, to_f}), 32'h0);

    // R7 park on chosen master
    wr(5'd0, 16'h0021);
    step();
    chk("R7 park on 2", 32'({gnt_d, gnt_f}), 32'h44);

    // R10 parked holder wins over others
    req = 4'b0101;
    step();
    chk("R10 holder keeps bus", 32'({gnt_d, gnt_f}), 32'h44);
    rd(5'd1, vd, vf);
    chk("R10 busy", 32'({vd[0], vf[0]}), 32'h3);
    demote(2);
    release_bus();
    chk("R7 reparked", 32'({gnt_d, gnt_f}), 32'h44);

    // R7 out-of-range park index
    wr(5'd0, 16'h0051);
    step();
    chk("R7 bad index no grant", 32'({gnt_d, gnt_f}), 32'h0);

    // R8 park on last granted
    wr(5'd0, 16'h0002);
    step();
    chk("R8 park last 2", 32'({gnt_d, gnt_f}), 32'h44);
    grant_chk("R8 grant", 4'b0010);
    release_bus();
    chk("R8 park last 1", 32'({gnt_d, gnt_f}), 32'h22);

    // R9 mode 3 parks nowhere
    wr(5'd0, 16'h0003);
    step();
    chk("R9 mode 3", 32'({gnt_d, gnt_f}), 32'h0);

    summary();
    $finish;
  end
endmodule